// File: doc/BRIEF.md
# Periodic Self-Test Scheduler with Busy Gating

This block decides when a measurement module runs its built-in open-circuit self-test. A 16-bit interval value, written over a small register port, gives the spacing between tests in units of an update-period tick that comes from outside the block. One tick stands for one slowest-update-rate period, roughly a quarter of a second. When the count of ticks reaches the programmed interval, the block issues a single-cycle start pulse to the test engine. It then waits for that engine's single-cycle done strobe. An interval of zero switches scheduling off.

Background calibration alignment can be requested at any time with a strobe. Each alignment occupies a fixed number of clock cycles. Self-tests and alignments share one busy flag. While that flag is high, a registered update-enable output is low, so the converter and temperature result registers hold their last values. Requests that overlap are queued and run back to back, and busy stays high without a gap between them. Busy can also be read in bit 0 of a status register.

Top module: `selftest_sched`

## Requirements
- R1: After reset, busy is 0, upd_en is 1, test_start is 0, and the interval register reads 0.
- R2: Reads with reg_addr 0 return the interval register, and writes with reg_addr 0 load it. Reads with reg_addr 1 return busy in bit 0 and zeros in bits 15:1.
- R3: While the interval is 0, no test is ever started.
- R4: With interval N ≥ 1, the tick counter starts from 0 after a write or after a test ends. test_start and busy rise in the cycle after the clock edge that samples the N-th tick. Ticks during a test are not counted.
- R5: test_start is high for exactly one cycle, and busy is high in that cycle.
- R6: A test keeps busy at 1 until the clock edge that samples test_done. If nothing is queued, busy is 0 afterwards.
- R7: In idle, an align_req makes busy 1 for exactly ALIGN_CYC cycles.
- R8: An align_req during a test is queued. The alignment starts at the done edge, and busy stays 1 without a gap.
- R9: upd_en equals the inverse of busy in every cycle.
- R10: Writing the interval register restarts the tick count from zero.
- R11: Writing 0 while a test runs lets that test finish, and no further test starts.
- R12: A test that falls due during an alignment is deferred. It starts in the cycle right after the alignment ends, and busy stays 1 across both.
- R13: test_done outside a running test has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = interval, 1 = status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| upd_tick | input | 1 | One-cycle tick, once per update period |
| align_req | input | 1 | Background alignment request strobe |
| test_done | input | 1 | One-cycle strobe from the test engine when a test finishes |
| test_start | output | 1 | One-cycle pulse that starts a test |
| busy | output | 1 | Test or alignment in progress |
| upd_en | output | 1 | Result-register update enable (low while busy) |

## Verification
The assertions assume that test_done arrives only as a single-cycle strobe while a test is running. They also assume that align_req and upd_tick are single-cycle strobes. The queued-alignment property additionally assumes that the test engine never raises done in the same cycle it receives start. The stimulus respects all of this: each strobe is driven for exactly one cycle, and done is raised only one or more cycles after a start has been observed. The one exception is a deliberate stray done sent in idle, where the assumptions place no limit on it.

// File: rtl/sts_pkg.sv
// Package: shared types and register addresses of the self-test scheduler.
// Assumes a one-bit register address space.
package sts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TEST  = 2'd1,
        ST_ALIGN = 2'd2
    } sts_state_e;

    localparam logic ADDR_IVL  = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/sts_ivl_regs.sv
// Module: interval register and read-back multiplexer.
// Holds the programmable test interval and returns interval or status.
// Assumes writes are single-cycle strobes; busy arrives already registered.
module sts_ivl_regs
    import sts_pkg::*;
#(
    parameter int IVL_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [IVL_W-1:0]  ivl,
    output logic              ivl_wr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - 1;

    // Decode a write to the interval register.
    always_comb begin
        ivl_wr = wr_en && (addr == ADDR_IVL);
    end

    // Store the interval value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl <= '0;
        end else if (ivl_wr) begin
            ivl <= wdata[IVL_W-1:0];
        end
    end

    // Select the read-back word.
    always_comb begin
        if (addr == ADDR_STAT) begin
            rdata = {{PAD_W{1'b0}}, busy};
        end else begin
            rdata = '0;
            rdata[IVL_W-1:0] = ivl;
        end
    end
endmodule

// File: rtl/sts_tick_cnt.sv
// Module: update-tick counter that flags when the next test falls due.
// Counts ticks only while run is high. Clears on an interval write and on due.
// A zero interval never produces due.
module sts_tick_cnt #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] ivl,
    input  logic             ivl_wr,
    input  logic             tick,
    input  logic             run,
    output logic             due
);
    localparam int EXT_W = IVL_W + 1;

    logic [IVL_W-1:0] cnt;
    logic [EXT_W-1:0] cnt_nx;

    // Detect when this tick completes the programmed interval.
    always_comb begin
        cnt_nx = {1'b0, cnt} + EXT_W'(1);
        due    = run && tick && !ivl_wr && (ivl != '0) && (cnt_nx == {1'b0, ivl});
    end

    // Advance or clear the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ivl_wr || due) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt_nx[IVL_W-1:0];
        end
    end
endmodule

// File: rtl/sts_seq.sv
// Module: test/alignment sequencer with a merged busy flag and update gating.
// Assumes test_done is a one-cycle strobe. An alignment lasts ALIGN_CYC cycles.
// Overlapping work is queued so that busy never drops between jobs.
module sts_seq
    import sts_pkg::*;
#(
    parameter int ALIGN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    input  logic align_req,
    input  logic test_done,
    output logic test_start,
    output logic busy,
    output logic upd_en,
    output logic in_test,
    output logic run,
    output logic pend_align_o
);
    localparam int ACW = (ALIGN_CYC < 2) ? 1 : $clog2(ALIGN_CYC);
    localparam logic [ACW-1:0] ALOAD = ACW'(ALIGN_CYC - 1);

    sts_state_e     state, state_n;
    logic [ACW-1:0] acnt, acnt_n;
    logic           pend_test, pend_test_n;
    logic           pend_align, pend_align_n;
    logic           start_n;

    // Work out the next state, the queue flags and the start pulse.
    always_comb begin
        state_n      = state;
        pend_test_n  = pend_test;
        pend_align_n = pend_align;
        start_n      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (due) begin
                    state_n      = ST_TEST;
                    start_n      = 1'b1;
                    pend_align_n = align_req;
                end else if (align_req) begin
                    state_n = ST_ALIGN;
                end
            end
            ST_TEST: begin
                if (test_done) begin
                    pend_align_n = 1'b0;
                    state_n      = (pend_align || align_req) ? ST_ALIGN : ST_IDLE;
                end else if (align_req) begin
                    pend_align_n = 1'b1;
                end
            end
            ST_ALIGN: begin
                if (due) begin
                    pend_test_n = 1'b1;
                end
                if (acnt == '0) begin
                    if (pend_test || due) begin
                        state_n     = ST_TEST;
                        start_n     = 1'b1;
                        pend_test_n = 1'b0;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Load the alignment timer on entry and count it down while aligning.
    always_comb begin
        acnt_n = acnt;
        if (state_n == ST_ALIGN && state != ST_ALIGN) begin
            acnt_n = ALOAD;
        end else if (state == ST_ALIGN && acnt != '0) begin
            acnt_n = acnt - ACW'(1);
        end
    end

    // Register the state, timer, queue flags and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            acnt       <= '0;
            pend_test  <= 1'b0;
            pend_align <= 1'b0;
            test_start <= 1'b0;
            upd_en     <= 1'b1;
        end else begin
            state      <= state_n;
            acnt       <= acnt_n;
            pend_test  <= pend_test_n;
            pend_align <= pend_align_n;
            test_start <= start_n;
            upd_en     <= (state_n == ST_IDLE);
        end
    end

    // Derive the status views of the registered state.
    always_comb begin
        busy         = (state != ST_IDLE);
        in_test      = (state == ST_TEST);
        run          = !in_test && !pend_test;
        pend_align_o = pend_align;
    end
endmodule

// File: rtl/selftest_sched.sv
// Module: top of the periodic self-test scheduler.
// Connects the interval register, the tick counter and the sequencer.
// Assumes every strobe input is synchronous to clk and one cycle long.
module selftest_sched #(
    parameter int IVL_W     = 16,
    parameter int DATA_W    = 16,
    parameter int ALIGN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              upd_tick,
    input  logic              align_req,
    input  logic              test_done,
    output logic              test_start,
    output logic              busy,
    output logic              upd_en
);
    logic [IVL_W-1:0] ivl_q;
    logic             ivl_wr;
    logic             due;
    logic             run;
    logic             in_test;
    logic             pend_align;

    sts_ivl_regs #(.IVL_W(IVL_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .ivl    (ivl_q),
        .ivl_wr (ivl_wr),
        .rdata  (reg_rdata)
    );

    sts_tick_cnt #(.IVL_W(IVL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ivl    (ivl_q),
        .ivl_wr (ivl_wr),
        .tick   (upd_tick),
        .run    (run),
        .due    (due)
    );

    sts_seq #(.ALIGN_CYC(ALIGN_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .due          (due),
        .align_req    (align_req),
        .test_done    (test_done),
        .test_start   (test_start),
        .busy         (busy),
        .upd_en       (upd_en),
        .in_test      (in_test),
        .run          (run),
        .pend_align_o (pend_align)
    );
endmodule

// File: rtl/sts_chk.sv
// Module: assertion checker for selftest_sched, attached with bind.
// Assumes test_done occurs only during a test and not in the start cycle.
module sts_chk #(
    parameter int IVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_start,
    input logic             busy,
    input logic             upd_en,
    input logic             test_done,
    input logic             align_req,
    input logic             in_test,
    input logic             pend_align,
    input logic [IVL_W-1:0] ivl_q
);
    // R5: the start pulse lasts one cycle.
    a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        test_start |=> !test_start);

    // R5: busy is high whenever start is.
    a_r5_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        test_start |-> busy);

    // R9: update enable is the inverse of busy.
    a_r9_upd_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en == !busy);

    // R3: a zero interval never starts a test from idle.
    a_r3_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_q == '0 && !busy) |=> !test_start);

    // R6: done with nothing queued ends busy.
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && test_done && !pend_align && !align_req) |=> !busy);

    // R8: done with alignment queued keeps busy high.
    a_r8_busy_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && test_done && (pend_align || align_req)) |=> (busy && !in_test));
endmodule

bind selftest_sched sts_chk #(.IVL_W(IVL_W)) u_sts_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_start (test_start),
    .busy       (busy),
    .upd_en     (upd_en),
    .test_done  (test_done),
    .align_req  (align_req),
    .in_test    (in_test),
    .pend_align (pend_align),
    .ivl_q      (ivl_q)
);

// File: tb/test_selftest_sched.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module test_selftest_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        upd_tick = 1'b0;
    logic        align_req = 1'b0;
    logic        test_done = 1'b0;
    logic        test_start;
    logic        busy;
    logic        upd_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    selftest_sched i_selftest_sched (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_tick(upd_tick),
        .align_req(align_req), .test_done(test_done), .test_start(test_start),
        .busy(busy), .upd_en(upd_en)
    );

    // Vector layout: wr, wdata[15:0], tick, align, done, exp_start, exp_busy.
    localparam int NV = 22;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {1'b1, 16'd3, 3'b000, 2'b00},  // write interval 3
        {1'b0, 16'd0, 3'b100, 2'b00},  // tick 1
        {1'b0, 16'd0, 3'b000, 2'b00},
        {1'b0, 16'd0, 3'b100, 2'b00},  // tick 2
        {1'b0, 16'd0, 3'b100, 2'b11},  // tick 3: R4 start
        {1'b0, 16'd0, 3'b000, 2'b01},  // R5 pulse over
        {1'b0, 16'd0, 3'b100, 2'b01},  // tick during test ignored
        {1'b0, 16'd0, 3'b001, 2'b00},  // R6 done
        {1'b0, 16'd0, 3'b100, 2'b00},  // tick 1
        {1'b0, 16'd0, 3'b100, 2'b00},  // tick 2
        {1'b0, 16'd0, 3'b010, 2'b01},  // R7 align from idle
        {1'b0, 16'd0, 3'b100, 2'b01},  // R12 due during align
        {1'b0, 16'd0, 3'b000, 2'b01},
        {1'b0, 16'd0, 3'b000, 2'b01},
        {1'b0, 16'd0, 3'b000, 2'b11},  // R12 deferred start
        {1'b0, 16'd0, 3'b010, 2'b01},  // R8 align queued
        {1'b0, 16'd0, 3'b001, 2'b01},  // R8 done, align begins
        {1'b0, 16'd0, 3'b000, 2'b01},
        {1'b0, 16'd0, 3'b000, 2'b01},
        {1'b0, 16'd0, 3'b000, 2'b01},
        {1'b0, 16'd0, 3'b000, 2'b00},  // R7 align over after 4 cycles
        {1'b0, 16'd0, 3'b001, 2'b00}   // R13 stray done
    };

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs; return just after the next falling edge.
    task automatic step(input logic wr, input logic [15:0] wd, input logic tk,
                        input logic al, input logic dn);
        reg_wr = wr; reg_wdata = wd; upd_tick = tk; align_req = al; test_done = dn;
        @(negedge clk);
        reg_wr = 1'b0; upd_tick = 1'b0; align_req = 1'b0; test_done = 1'b0;
    endtask

    // Check both flags and their inverse relation.
    task automatic chk_out(input string req, input logic s, input logic b);
        chk({req, " start"}, {15'd0, test_start}, {15'd0, s});
        chk({req, " busy"}, {15'd0, busy}, {15'd0, b});
        chk("R9 upd_en", {15'd0, upd_en}, {15'd0, ~b});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 upd_en", {15'd0, upd_en}, 16'd1);
        chk("R1 start", {15'd0, test_start}, 16'd0);
        chk("R1 interval", reg_rdata, 16'd0);
        // R3 ticks with zero interval
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
            chk_out("R3", 1'b0, 1'b0);
        end
        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21], VEC[i][20:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            chk_out($sformatf("vec%0d R4-R13", i), VEC[i][1], VEC[i][0]);
        end
        // R10 rewrite restarts the count
        step(1'b1, 16'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 16'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
        chk_out("R10 no early", 1'b0, 1'b0);
        step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
        chk_out("R10 start", 1'b1, 1'b1);
        // R2 status read while busy
        reg_addr = 1'b1;
        #1 chk("R2 status", reg_rdata, 16'h0001);
        reg_addr = 1'b0;
        // R11 write zero during test
        step(1'b1, 16'd0, 1'b0, 1'b0, 1'b0);
        chk_out("R11 still busy", 1'b0, 1'b1);
        chk("R11 interval", reg_rdata, 16'd0);
        step(1'b0, 16'd0, 1'b0, 1'b0, 1'b1);
        chk_out("R11 done", 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
            chk_out("R11 R3 none", 1'b0, 1'b0);
        end
        reg_addr = 1'b1;
        #1 chk("R2 status idle", reg_rdata, 16'h0000);
        reg_addr = 1'b0;
        // R4 interval of one
        step(1'b1, 16'd1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin
            step(1'b0, 16'd0, 1'b1, 1'b0, 1'b0);
            chk_out("R4 n1 start", 1'b1, 1'b1);
            step(1'b0, 16'd0, 1'b0, 1'b0, 1'b1);
            chk_out("R4 n1 done", 1'b0, 1'b0);
        end
        // R2 readback
        step(1'b1, 16'hA5C3, 1'b0, 1'b0, 1'b0);
        chk("R2 readback", reg_rdata, 16'hA5C3);
        step(1'b1, 16'd0, 1'b0, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule